// File: doc/BRIEF.md
# USB Data and Handshake Packet Transmitter

This block assembles USB data packets and handshake packets and streams them byte by byte over a UTMI-style transmit port. A one-cycle start request supplies a 4-bit packet identifier and a payload length. For a data packet the block sends the identifier byte, then the payload bytes, then two CRC16 check bytes that it accumulates as the payload goes out. For a handshake packet it sends the identifier byte alone. NRZI coding, bit stuffing, end-of-packet signalling and buffer management are left to other blocks.

Payload bytes come from a simple byte-read port. The block drives an address, and the data returned at that address must be valid in the same cycle and held steady while the address is unchanged. The transmit side is valid/ready. `tx_valid_o` rises together with the first byte and stays high until the last byte is accepted. A byte counts as accepted on a rising clock edge where `tx_valid_o` and `tx_ready_i` are both high. The block presents the next byte only after such an edge, so the sink can stall it by holding `tx_ready_i` low for as many cycles as it needs.

Top module: `usb_pkt_tx`

## Requirements
- R1: The first byte of every packet carries the identifier in bits 3:0 and its bitwise complement in bits 7:4.
- R2: A data packet is exactly length+3 bytes long: the identifier byte, then the payload bytes in read-port address order from 0, then the two check bytes.
- R3: The check bytes follow the USB CRC16 rule. Seed the register with 0xFFFF and feed each payload byte least-significant bit first through polynomial x^16+x^15+x^2+1 in its reflected form (0xA001). The first check byte sent is the complement of the reflected register's low byte, and the second is the complement of its high byte.
- R4: A zero payload length produces a three-byte packet: the identifier and the check bytes 0x00, 0x00.
- R5: An identifier whose bits 1:0 equal 2'b10 is a handshake and produces a one-byte packet with no payload and no check bytes.
- R6: `tx_valid_o` rises in the cycle after start is sampled, stays high without a gap until the final byte is accepted, and is low in the cycle after that.
- R7: While `tx_ready_i` is low, `tx_data_o` holds its value. The next byte appears only in the cycle after an accepting edge.
- R8: A start request made while `busy_o` is high is ignored. The packet in flight is unchanged, and no second packet follows it.
- R9: `busy_o` is high from the cycle after start up to and including the cycle of the final acceptance. `done_o` pulses high for exactly one cycle right after the final acceptance. After reset, busy, valid and done are all low.
- R10: Payload lengths up to 1023 bytes, given on a 10-bit length input, are sent in full with a correct check value.
- R11: While a payload byte is on `tx_data_o`, `rd_addr_o` equals that byte's index within the payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| pid_i | input | 4 | Packet identifier |
| len_i | input | 10 | Payload length in bytes |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |
| rd_addr_o | output | 10 | Payload read address |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, same cycle |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Sink accepts the byte on this edge |
| tx_data_o | output | 8 | Transmit byte |

## Verification
After a sampled start, the identifier byte and `tx_valid_o` are due one cycle later. Each following byte is due one cycle after the edge that accepted the previous byte, and `done_o` together with the fall of `busy_o` and `tx_valid_o` is due one cycle after the final acceptance. The bench holds a reference model that advances by exactly these rules. Each rising edge steps the model on the inputs driven for that edge, and the model's expected valid, data, address, busy and done values are compared with the ports at the following falling edge. The model is exercised with a constantly ready sink and with a random stalling sink, across zero, short and maximum payload lengths, handshake identifiers, starts raised mid-packet, and back-to-back packets.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PID,
    ST_DATA,
    ST_CRC_HI,
    ST_CRC_LO
  } tx_state_e;

  // Handshake identifiers share the low bit pair 2'b10
  function automatic logic is_handshake(input logic [3:0] pid);
    return pid[1:0] == 2'b10;
  endfunction
endpackage

// File: rtl/usb_crc16_acc.sv
module usb_crc16_acc #(
  parameter int          CRC_W = 16,
  parameter int          DW    = 8,
  parameter logic [15:0] POLY  = 16'h8005,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] first_o,
  output logic [DW-1:0] second_o
);
  localparam int HALF = CRC_W / 2;

  logic [CRC_W-1:0] crc_q, crc_nxt;

  // Shift-left register, payload bits fed LSB first
  always_comb begin
    crc_nxt = crc_q;
    for (int i = 0; i < DW; i++) begin
      if (crc_nxt[CRC_W-1] ^ byte_i[i])
        crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      else
        crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= SEED[CRC_W-1:0];
    else if (clear_i) crc_q <= SEED[CRC_W-1:0];
    else if (en_i)    crc_q <= crc_nxt;
  end

  // Each output byte is a bit-reversed, complemented register half
  for (genvar g = 0; g < HALF; g++) begin : g_rev
    assign first_o[g]  = ~crc_q[CRC_W-1-g];
    assign second_o[g] = ~crc_q[HALF-1-g];
  end
endmodule

// File: rtl/usb_tx_seq.sv
module usb_tx_seq
  import usb_tx_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       pid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tx_ready_i,
  output tx_state_e        state_o,
  output logic [LEN_W-1:0] idx_o,
  output logic [3:0]       pid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             crc_clear_o,
  output logic             crc_en_o
);
  tx_state_e        state_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [3:0]       pid_q;
  logic             done_q, finish, last_data;

  assign last_data   = idx_q == len_q - LEN_W'(1);
  assign crc_clear_o = (state_q == ST_IDLE) && start_i;
  assign crc_en_o    = (state_q == ST_DATA) && tx_ready_i;
  assign finish      = tx_ready_i &&
                       ((state_q == ST_CRC_LO) ||
                        (state_q == ST_PID && is_handshake(pid_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      pid_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pid_q   <= pid_i;
          len_q   <= len_i;
          idx_q   <= '0;
          state_q <= ST_PID;
        end
        ST_PID: if (tx_ready_i) begin
          if (is_handshake(pid_q)) state_q <= ST_IDLE;
          else if (len_q == '0)    state_q <= ST_CRC_HI;
          else                     state_q <= ST_DATA;
        end
        ST_DATA: if (tx_ready_i) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_data) state_q <= ST_CRC_HI;
        end
        ST_CRC_HI: if (tx_ready_i) state_q <= ST_CRC_LO;
        ST_CRC_LO: if (tx_ready_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign pid_o   = pid_q;
  assign busy_o  = state_q != ST_IDLE;
  assign done_o  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q && state_q == ST_IDLE); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && start_i |=> $stable(pid_q) && $stable(len_q)); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DATA |-> idx_q < len_q); // R10
endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx
  import usb_tx_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       pid_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [DW-1:0]    rd_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [DW-1:0]    tx_data_o
);
  tx_state_e        state;
  logic [LEN_W-1:0] idx;
  logic [3:0]       pid_q;
  logic             crc_clear, crc_en;
  logic [DW-1:0]    crc_first, crc_second;

  usb_tx_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pid_i       (pid_i),
    .len_i       (len_i),
    .tx_ready_i  (tx_ready_i),
    .state_o     (state),
    .idx_o       (idx),
    .pid_o       (pid_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .crc_clear_o (crc_clear),
    .crc_en_o    (crc_en)
  );

  usb_crc16_acc #(.CRC_W(16), .DW(DW)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (crc_clear),
    .en_i     (crc_en),
    .byte_i   (rd_data_i),
    .first_o  (crc_first),
    .second_o (crc_second)
  );

  assign rd_addr_o  = idx;
  assign tx_valid_o = state != ST_IDLE;

  always_comb begin
    unique case (state)
      ST_PID:    tx_data_o = DW'({~pid_q, pid_q});
      ST_DATA:   tx_data_o = rd_data_i;
      ST_CRC_HI: tx_data_o = crc_first;
      ST_CRC_LO: tx_data_o = crc_second;
      default:   tx_data_o = '0;
    endcase
  end

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> $stable(tx_data_o)); // R7
  AST_VALID_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> tx_valid_o && tx_data_o[7:4] == ~tx_data_o[3:0]); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tx_valid_o); // R9
endmodule

// File: tb/tb_usb_pkt_tx.sv
`timescale 1ns/1ps
module tb_usb_pkt_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] pid_i = '0;
  logic [9:0] len_i = '0;
  logic       busy_o, done_o, tx_valid_o;
  logic       tx_ready_i = 1'b1;
  logic [9:0] rd_addr_o;
  logic [7:0] rd_data_i, tx_data_o;
  logic [7:0] mem [1024];

  int vectors = 0, miscompares = 0, cycles = 0;
  bit random_ready = 1'b0;

  always #2 clk = ~clk;

  assign rd_data_i = mem[rd_addr_o];

  usb_pkt_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pid_i(pid_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o)
  );

  // Reference model: expected byte stream with tags and payload addresses
  byte unsigned exp_q[$];
  string        tag_q[$];
  int           adr_q[$];
  bit           busy_m = 1'b0, done_m = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input logic [3:0] pid, input int len);
    logic [15:0] r;
    exp_q.push_back({~pid, pid}); tag_q.push_back("R1"); adr_q.push_back(-1);
    if (pid[1:0] == 2'b10) return;  // R5 handshake: one byte
    r = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(mem[i]); tag_q.push_back("R2"); adr_q.push_back(i);
      r = r ^ {8'h00, mem[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    exp_q.push_back(~r[7:0]);  tag_q.push_back("R3"); adr_q.push_back(-1);
    exp_q.push_back(~r[15:8]); tag_q.push_back("R3"); adr_q.push_back(-1);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); tag_q.delete(); adr_q.delete();
      busy_m = 1'b0; done_m = 1'b0;
      check(!busy_o && !tx_valid_o && !done_o, "R9 reset", {busy_o, tx_valid_o, done_o}, 0);
    end else begin
      bit acc_start;
      check(tx_valid_o == (exp_q.size() != 0), "R6 valid", tx_valid_o, exp_q.size() != 0);
      check(busy_o == busy_m, "R9 busy", busy_o, busy_m);
      check(done_o == done_m, "R9 done", done_o, done_m);
      if (exp_q.size() != 0 && tx_valid_o) begin
        check(tx_data_o == exp_q[0], tag_q[0], tx_data_o, exp_q[0]); // R7 R4 R10
        if (adr_q[0] >= 0)
          check(int'(rd_addr_o) == adr_q[0], "R11 addr", rd_addr_o, adr_q[0]);
      end
      acc_start = !busy_m && start_i;   // R8: start while busy is dropped
      done_m = 1'b0;
      if (busy_m && tx_ready_i && exp_q.size() != 0) begin
        void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(adr_q.pop_front());
        if (exp_q.size() == 0) begin busy_m = 1'b0; done_m = 1'b1; end
      end
      if (acc_start) begin
        build(pid_i, int'(len_i));
        busy_m = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    #1 tx_ready_i <= random_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
  endtask

  task automatic send(input logic [3:0] pid, input int len);
    @(posedge clk); #1;
    start_i = 1'b1; pid_i = pid; len_i = 10'(len);
    @(posedge clk); #1;
    start_i = 1'b0;
    do @(negedge clk); while (!done_o);
  endtask

  initial begin
    fill(5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    send(4'b0011, 0);       // R4 zero-length DATA0
    send(4'b1011, 1);       // R2 single byte DATA1
    send(4'b0011, 5);       // R3 short payload
    send(4'b0010, 7);       // R5 ACK, length ignored
    send(4'b1010, 0);       // R5 NAK
    random_ready = 1'b1;
    send(4'b1011, 40);      // R7 stalling sink
    send(4'b1110, 3);       // R5 STALL under stalls
    send(4'b0011, 0);       // R4 under stalls
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    send(4'b0011, 16);      // R3 all-ones payload
    fill(91);
    // R8: start pulses mid-packet must be ignored
    @(posedge clk); #1; start_i = 1'b1; pid_i = 4'b1011; len_i = 10'd20;
    @(posedge clk); #1; start_i = 1'b0;
    repeat (6) @(posedge clk);
    #1; start_i = 1'b1; pid_i = 4'b0010; len_i = 10'd3;
    @(posedge clk); #1; start_i = 1'b0;
    do @(negedge clk); while (!done_o);
    repeat (4) @(negedge clk);   // nothing further may be sent (R8)
    random_ready = 1'b0;
    send(4'b0011, 1023);    // R10 maximum length
    random_ready = 1'b1;
    send(4'b1011, 1023);    // R10 maximum length with stalls
    random_ready = 1'b0;
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule